// File: doc/BRIEF.md
# One-Dimensional Lifting Wavelet Filter

This block performs one level of a one-dimensional discrete wavelet decomposition on a line of up to 128 signed 16-bit samples. Samples arrive on a valid/ready stream with start-of-line and end-of-line markers. Each line is gathered into a local line store and transformed in place by a sequence of lifting passes. The coefficients then leave on a second valid/ready stream in natural interleaved order: low-pass, high-pass, low-pass, and so on.

A mode pin selects between two filters. The reversible integer 5/3 filter uses two lifting passes. The irreversible 9/7 filter uses four fixed-point lifting passes plus a scaling pass. At both ends of the line, the block applies whole-sample symmetric mirroring. This works for any length from 1 to the store depth, so lines of one, two or three samples are handled correctly.

Back-pressure rules: the input side accepts one sample per clock while a line is being gathered. From the end of a line until its last coefficient has been taken, `in_ready` stays low. On the output side, a coefficient is transferred on every cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered coefficient and its tags are held unchanged.

Top module: `wavelet_lift_1d`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. While gathering, one sample is taken on each clock edge where `in_valid` and `in_ready` are both 1. A sample with `in_sol`=1 restarts the line at index 0.
- R2: A line ends with the sample that carries `in_eol`=1, or with the sample that brings the count up to the programmed length, whichever comes first. `in_ready` is then 0 until the last coefficient of that line has been transferred, and returns to 1 on the next cycle.
- R3: Coefficients leave in index order 0..N-1. `out_high` is 0 at even indices (low-pass) and 1 at odd indices (high-pass), so the first coefficient is low-pass. `out_last` is 1 only on index N-1.
- R4: In mode 0 (5/3), every odd sample becomes d = x - floor((left + right) / 2).
- R5: In mode 0, after R4, every even sample becomes s = x + floor((left + right + 2) / 4), using the updated odd neighbours.
- R6: Neighbours are mirrored at the line ends: the left neighbour of index 0 is index 1, and the right neighbour of index N-1 is index N-2. This holds for N=2 and N=3 as well.
- R7: In mode 1 (9/7), four lifting passes run in the order odd, even, odd, even. Their Q14 constants are -25987, -868, 14466 and 7266. Each pass computes x + ((c * (left + right) + 8192) >>> 14).
- R8: In mode 1, a final scaling pass computes (k * x + 8192) >>> 14, with k = 13318 at even indices and k = 20155 at odd indices.
- R9: The result of every pass is saturated to the signed 16-bit range [-32768, 32767].
- R10: A line of length 1 is returned unchanged as a single low-pass coefficient in either mode.
- R11: While `out_valid` is 1 and `out_ready` is 0, the values of `out_data`, `out_high` and `out_last` do not change.
- R12: `cfg_mode` (0 = 5/3, 1 = 9/7) and `cfg_len` (1 to 128) are latched with the first sample of a line. Changes to them later in the same line have no effect.
- R13: The first coefficient is offered N+1 cycles after the edge that ends the line in mode 0, and 3N+1 cycles after it in mode 1. For N=1 it is offered on the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Filter select: 0 = 5/3, 1 = 9/7 |
| cfg_len | input | 8 | Programmed line length (1..128) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high |
| in_data | input | 16 | Signed input sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_eol | input | 1 | Sample is the last of a line |
| out_valid | output | 1 | Coefficient valid |
| out_ready | input | 1 | Downstream takes coefficient when high |
| out_data | output | 16 | Signed coefficient |
| out_high | output | 1 | 1 = high-pass, 0 = low-pass |
| out_last | output | 1 | Final coefficient of the line |

## Verification
The first coefficient of a line is due N+1 cycles after the line-ending edge in 5/3 mode, 3N+1 cycles after it in 9/7 mode, and on the next cycle for a one-sample line. The bench counts falling edges from the line-ending edge until `out_valid` appears and compares that count with the expected one. Drain values are checked only on handshakes, which are decided at the falling edge where `out_ready` is driven. A stall is checked by comparing the held coefficient at the next falling edge. `in_ready` is checked low on the first falling edge after a line ends and high on the first falling edge after its last coefficient.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [1:0] {ST_FILL, ST_LIFT, ST_DRAIN} st_t;
  typedef enum logic [2:0] {OP_PRED, OP_UPD, OP_LIFT, OP_SCALE, OP_DONE} op_t;

  localparam int FRAC = 14;
  localparam int CW   = 18;

  localparam logic signed [CW-1:0] C_P1 = -18'sd25987;
  localparam logic signed [CW-1:0] C_U1 = -18'sd868;
  localparam logic signed [CW-1:0] C_P2 = 18'sd14466;
  localparam logic signed [CW-1:0] C_U2 = 18'sd7266;
  localparam logic signed [CW-1:0] K_LO = 18'sd13318;
  localparam logic signed [CW-1:0] K_HI = 18'sd20155;

  // Pass schedule per mode.
  function automatic op_t op_of(input logic m, input logic [2:0] p);
    op_t r;
    r = OP_DONE;
    if (!m) begin
      case (p)
        3'd0:    r = OP_PRED;
        3'd1:    r = OP_UPD;
        default: r = OP_DONE;
      endcase
    end else begin
      case (p)
        3'd0, 3'd1, 3'd2, 3'd3: r = OP_LIFT;
        3'd4:                   r = OP_SCALE;
        default:                r = OP_DONE;
      endcase
    end
    return r;
  endfunction

  // Whether a pass visits odd indices.
  function automatic logic pass_odd(input logic m, input logic [2:0] p);
    return m ? (p == 3'd0 || p == 3'd2) : (p == 3'd0);
  endfunction

  function automatic logic signed [CW-1:0] coef_of(input logic [2:0] p);
    logic signed [CW-1:0] c;
    case (p)
      3'd0:    c = C_P1;
      3'd1:    c = C_U1;
      3'd2:    c = C_P2;
      3'd3:    c = C_U2;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lift_store.sv
module lift_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] addr_x,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  output logic [DW-1:0] q_x,
  output logic [DW-1:0] q_l,
  output logic [DW-1:0] q_r
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign q_x = mem[addr_x];
  assign q_l = mem[addr_l];
  assign q_r = mem[addr_r];

endmodule

// File: rtl/lift_alu.sv
module lift_alu
  import lift_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_t                    op,
  input  logic signed [CW-1:0]   coef,
  input  logic                   odd,
  input  logic signed [DW-1:0]   x,
  input  logic signed [DW-1:0]   nl,
  input  logic signed [DW-1:0]   nr,
  output logic        [DW-1:0]   y
);

  localparam int EW = DW + CW + 6;
  localparam logic signed [EW-1:0] RND  = EW'(1) <<< (FRAC - 1);
  localparam logic signed [EW-1:0] TWO  = EW'(2);
  localparam logic signed [EW-1:0] MAXV = (EW'(1) <<< (DW - 1)) - EW'(1);
  localparam logic signed [EW-1:0] MINV = -(EW'(1) <<< (DW - 1));

  logic signed [EW-1:0] xe, le, re, se, ce, ke, raw;

  always_comb begin
    xe  = x;
    le  = nl;
    re  = nr;
    ce  = coef;
    ke  = odd ? K_HI : K_LO;
    se  = le + re;
    case (op)
      OP_PRED:  raw = xe - (se >>> 1);
      OP_UPD:   raw = xe + ((se + TWO) >>> 2);
      OP_LIFT:  raw = xe + (((ce * se) + RND) >>> FRAC);
      OP_SCALE: raw = ((ke * xe) + RND) >>> FRAC;
      default:  raw = xe;
    endcase
    if (raw > MAXV)      y = MAXV[DW-1:0];
    else if (raw < MINV) y = MINV[DW-1:0];
    else                 y = raw[DW-1:0];
  end

endmodule

// File: rtl/lift_seq.sv
module lift_seq
  import lift_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mode,
  input  logic [LW-1:0]        cfg_len,
  input  logic                 in_valid,
  input  logic                 in_sol,
  input  logic                 in_eol,
  input  logic                 out_ready,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_high,
  output logic                 out_last,
  output logic                 we,
  output logic                 wsel_alu,
  output logic [AW-1:0]        waddr,
  output logic [AW-1:0]        addr_x,
  output logic [AW-1:0]        addr_l,
  output logic [AW-1:0]        addr_r,
  output op_t                  op,
  output logic signed [CW-1:0] coef,
  output logic                 odd
);

  st_t           st;
  logic [LW-1:0] cnt, len, idx;
  logic          mode;
  logic [2:0]    pidx;

  logic [LW-1:0] lenc, fpos, flen, left_i, right_i;
  logic [LW:0]   nidx;
  logic          end_line;
  op_t           cur_op;

  always_comb begin
    if (cfg_len == '0)             lenc = LW'(1);
    else if (cfg_len > LW'(DEPTH)) lenc = LW'(DEPTH);
    else                           lenc = cfg_len;
    fpos     = in_sol ? '0 : cnt;
    flen     = (fpos == '0) ? lenc : len;
    end_line = in_eol || ((fpos + LW'(1)) == flen);
    cur_op   = op_of(mode, pidx);
    left_i   = (idx == '0) ? LW'(1) : idx - LW'(1);
    right_i  = ((idx + LW'(1)) >= len) ? idx - LW'(1) : idx + LW'(1);
    nidx     = {1'b0, idx} + ((cur_op == OP_SCALE) ? (LW+1)'(1) : (LW+1)'(2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_FILL;
      cnt  <= '0;
      len  <= LW'(1);
      idx  <= '0;
      mode <= 1'b0;
      pidx <= '0;
    end else begin
      case (st)
        ST_FILL: begin
          if (in_valid) begin
            cnt <= fpos + LW'(1);
            if (fpos == '0) begin
              mode <= cfg_mode;
              len  <= lenc;
            end
            if (end_line) begin
              len  <= fpos + LW'(1);
              pidx <= '0;
              idx  <= (fpos == '0) ? '0 : LW'(1);
              st   <= (fpos == '0) ? ST_DRAIN : ST_LIFT;
            end
          end
        end
        ST_LIFT: begin
          if (cur_op == OP_DONE) begin
            st  <= ST_DRAIN;
            idx <= '0;
          end else if (nidx >= {1'b0, len}) begin
            pidx <= pidx + 3'd1;
            idx  <= pass_odd(mode, pidx + 3'd1) ? LW'(1) : '0;
          end else begin
            idx <= nidx[LW-1:0];
          end
        end
        default: begin
          if (out_ready) begin
            if (out_last) begin
              st  <= ST_FILL;
              cnt <= '0;
              idx <= '0;
            end else begin
              idx <= idx + LW'(1);
            end
          end
        end
      endcase
    end
  end

  assign in_ready  = (st == ST_FILL);
  assign out_valid = (st == ST_DRAIN);
  assign out_high  = idx[0];
  assign out_last  = ((idx + LW'(1)) == len);
  assign we        = (st == ST_FILL && in_valid) || (st == ST_LIFT && cur_op != OP_DONE);
  assign wsel_alu  = (st == ST_LIFT);
  assign waddr     = (st == ST_FILL) ? fpos[AW-1:0] : idx[AW-1:0];
  assign addr_x    = idx[AW-1:0];
  assign addr_l    = left_i[AW-1:0];
  assign addr_r    = right_i[AW-1:0];
  assign op        = cur_op;
  assign coef      = coef_of(pidx);
  assign odd       = idx[0];

endmodule

// File: rtl/wavelet_lift_1d.sv
module wavelet_lift_1d
  import lift_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic [LW-1:0] cfg_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_high,
  output logic          out_last
);

  logic                 we, wsel_alu, odd;
  logic [AW-1:0]        waddr, addr_x, addr_l, addr_r;
  logic [DW-1:0]        q_x, q_l, q_r, alu_y, wdata;
  op_t                  op;
  logic signed [CW-1:0] coef;

  lift_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_high(out_high), .out_last(out_last),
    .we(we), .wsel_alu(wsel_alu), .waddr(waddr), .addr_x(addr_x), .addr_l(addr_l),
    .addr_r(addr_r), .op(op), .coef(coef), .odd(odd)
  );

  lift_alu #(.DW(DW)) u_alu (
    .op(op), .coef(coef), .odd(odd), .x(q_x), .nl(q_l), .nr(q_r), .y(alu_y)
  );

  assign wdata = wsel_alu ? alu_y : in_data;

  lift_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .addr_x(addr_x), .addr_l(addr_l), .addr_r(addr_r),
    .q_x(q_x), .q_l(q_l), .q_r(q_r)
  );

  assign out_data = q_x;

endmodule

// File: rtl/wavelet_lift_1d_chk.sv
module wavelet_lift_1d_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_eol,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_high,
  input logic          out_last
);

  assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eol) |=> !in_ready);

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && (out_high != $past(out_high))));

  assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_high);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_high)
                                   && $stable(out_last)));

endmodule

bind wavelet_lift_1d wavelet_lift_1d_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eol(in_eol),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_high(out_high), .out_last(out_last)
);

// File: tb/wavelet_lift_1d_tb.sv
module wavelet_lift_1d_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [7:0]  cfg_len = 8'd1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_sol = 1'b0;
  logic        in_eol = 1'b0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_high, out_last;
  logic [15:0] out_data;

  int vectors = 0;
  int fails = 0;
  int m [128];

  always #2 clk = ~clk;

  wavelet_lift_1d u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sol(in_sol),
    .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_high(out_high), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int lf(input int i);
    return (i == 0) ? 1 : i - 1;
  endfunction

  function automatic int rt(input int i, input int n);
    return (i + 1 >= n) ? i - 1 : i + 1;
  endfunction

  task automatic model(input int n, input int mode);
    longint s, k;
    longint cs [4];
    cs[0] = -25987; cs[1] = -868; cs[2] = 14466; cs[3] = 7266;
    if (n < 2) return;
    if (mode == 0) begin
      for (int i = 1; i < n; i += 2) begin
        s = longint'(m[lf(i)]) + longint'(m[rt(i, n)]);
        m[i] = int'(sat16(longint'(m[i]) - (s >>> 1)));
      end
      for (int i = 0; i < n; i += 2) begin
        s = longint'(m[lf(i)]) + longint'(m[rt(i, n)]);
        m[i] = int'(sat16(longint'(m[i]) + ((s + 2) >>> 2)));
      end
    end else begin
      for (int p = 0; p < 4; p++) begin
        for (int i = (p % 2 == 0) ? 1 : 0; i < n; i += 2) begin
          s = longint'(m[lf(i)]) + longint'(m[rt(i, n)]);
          m[i] = int'(sat16(longint'(m[i]) + ((cs[p] * s + 8192) >>> 14)));
        end
      end
      for (int i = 0; i < n; i++) begin
        k = (i % 2 == 1) ? 20155 : 13318;
        m[i] = int'(sat16((k * longint'(m[i]) + 8192) >>> 14));
      end
    end
  endtask

  // Entered and left at a falling edge.
  task automatic push(input logic [15:0] d, input logic sol, input logic eol);
    bit rdy;
    in_valid = 1'b1; in_data = d; in_sol = sol; in_eol = eol;
    forever begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  task automatic receive(input int n, input int mode, input string tag);
    int got = 0;
    bit pend = 0;
    logic [15:0] hd = '0;
    string tg;
    while (got < n) begin
      out_ready = ($urandom % 4) != 0;
      if (pend) begin
        check(out_valid && out_data == hd, "R11", "held coefficient", int'(out_data), int'(hd));
        pend = 0;
      end
      if (out_valid && out_ready) begin
        if (tag != "") tg = tag;
        else if (n == 1) tg = "R10";
        else if (n <= 3) tg = "R6";
        else if (mode == 0) tg = got[0] ? "R4" : "R5";
        else tg = got[0] ? "R7" : "R8";
        check(out_data == m[got][15:0], tg, $sformatf("coef %0d", got),
              int'($signed(out_data)), m[got]);
        check(out_high == got[0], "R3", "out_high", int'(out_high), got % 2);
        check(out_last == (got == n - 1), "R3", "out_last", int'(out_last), int'(got == n - 1));
        got++;
      end else if (out_valid) begin
        pend = 1;
        hd = out_data;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(in_ready == 1'b1, "R2", "in_ready after last coef", int'(in_ready), 1);
  endtask

  // kind: 0 random, 1 full-scale alternating, 2 ramp
  task automatic run_line(input int n, input int mode, input int cfglen, input bit use_eol,
                          input int kind, input bit gaps, input bit flip, input string tag);
    int w, lat;
    for (int i = 0; i < n; i++) begin
      case (kind)
        1:       m[i] = (i % 2 == 0) ? 32767 : -32768;
        2:       m[i] = i * 97 - 5000;
        default: m[i] = int'($signed(16'($urandom)));
      endcase
    end
    cfg_mode = mode[0];
    cfg_len = 8'(cfglen);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) @(negedge clk);
      push(m[i][15:0], i == 0, use_eol && (i == n - 1));
      if (i == 0 && flip) begin
        cfg_mode = ~mode[0];
        cfg_len = 8'd2;
      end
    end
    model(n, mode);
    check(in_ready == 1'b0, "R2", "in_ready after line end", int'(in_ready), 0);
    lat = (n == 1) ? 0 : ((mode == 0) ? n + 1 : 3 * n + 1);
    w = 0;
    while (!out_valid && w < 600) begin
      @(negedge clk);
      w++;
    end
    check(w == lat, "R13", "first coefficient latency", w, lat);
    receive(n, mode, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);

    // directed corners
    run_line(1, 0, 1, 1, 0, 0, 0, "R10");
    run_line(1, 1, 1, 0, 0, 0, 0, "R10");
    run_line(2, 0, 2, 0, 0, 0, 0, "R6");
    run_line(2, 1, 2, 1, 0, 0, 0, "R6");
    run_line(3, 0, 3, 1, 2, 0, 0, "R6");
    run_line(3, 1, 3, 0, 2, 0, 0, "R6");
    run_line(16, 0, 16, 0, 1, 0, 0, "R9");
    run_line(16, 1, 16, 1, 1, 0, 0, "R9");
    run_line(7, 0, 20, 1, 0, 1, 0, "R2");
    run_line(12, 1, 12, 0, 0, 0, 1, "R12");
    run_line(9, 0, 9, 0, 0, 0, 1, "R12");
    run_line(128, 0, 128, 0, 0, 0, 0, "");
    run_line(128, 1, 128, 1, 2, 0, 0, "");

    // restart with a start-of-line marker mid-line
    cfg_mode = 1'b0;
    cfg_len = 8'd40;
    push(16'd111, 1'b1, 1'b0);
    push(16'd222, 1'b0, 1'b0);
    push(16'd333, 1'b0, 1'b0);
    run_line(5, 1, 5, 0, 0, 1, 0, "R1");

    // constrained random lines
    for (int t = 0; t < 30; t++) begin
      int n, md;
      bit ue;
      n = 1 + int'($urandom % 128);
      md = int'($urandom % 2);
      ue = ($urandom % 2) == 1;
      run_line(n, md, ue ? 128 : n, ue, int'($urandom % 3), ($urandom % 2) == 1, 0, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule